// File: doc/BRIEF.md
# Fixed-Feature Power-Management Register Block

This block holds the fixed power-management registers that an operating system's power driver reads and writes through byte-addressed I/O: an event status word, an event enable word, a control word and a one-byte command port that hands power-management control to the OS or takes it back. It drives a level-sensitive system-control interrupt and takes a pulse from an external power button.

Each I/O request carries an address, a byte count, a write flag and write data. The block checks that the access size suits the addressed register. It applies a per-register write mask and returns read data and an error flag one cycle later. The interrupt is held active for as long as any enabled event status bit is set. A control write that sets the sleep-enable bit together with the soft-off sleep-type code produces a one-cycle soft-off pulse, which the platform uses to cut power.

Top module: `pm_fixed_regs`

## Requirements
- R1: The status word is at 0x400, the enable word at 0x402 and the control word at 0x404, and each accepts only a 2-byte access. The command port at 0xB2 accepts only a 1-byte access. A request to any of these four addresses with another byte count raises `io_err` in the following cycle, returns 0 and changes no state.
- R2: A status write clears each of bits 15, 10, 9, 8 and 4 where the written data holds a 1. It leaves those bits alone where the data holds a 0, and it never changes any other status bit.
- R3: An enable write stores only bits 8 (power button) and 5 (global). Every other enable bit always reads 0.
- R4: `sci_irq` is active low. It is 0 exactly while status and enable share a set bit among 0, 5, 8, 9 and 10. It follows any register change in the cycle after the change.
- R5: A `pwr_btn` pulse sets status bit 8 only while control bit 0 (OS control active) is 1. If the bit is already set, the pulse has no effect.
- R6: Writing 0xA0 to the command port sets control bit 0, and writing 0xA1 clears it. Any other value written there changes nothing. Reads of the command port return 0.
- R7: A control write keeps the current value of control bit 0. It stores the written bits except bits 15, 14, 13, 1 and 0, which are stored as 0.
- R8: A control write whose data has bit 13 set and bits 12:10 equal to the soft-off code (parameter, default 5) drives `soft_off` high for exactly the cycle after the write. No other write raises it.
- R9: After reset, status, enable and control read 0, `sci_irq` is 1 and OS control is inactive.
- R10: Read data is returned in the cycle after the request. A request to an unmapped address reads 0 and does not raise `io_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_req | input | 1 | I/O request valid this cycle |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | ADDR_W | Byte I/O address |
| io_size | input | 3 | Access size in bytes |
| io_wdata | input | 16 | Write data (command port uses bits 7:0) |
| io_rdata | output | 16 | Read data, one cycle after the request |
| io_err | output | 1 | Size error for the previous request |
| pwr_btn | input | 1 | Power-button event pulse |
| sci_irq | output | 1 | Level system-control interrupt, active low by default |
| soft_off | output | 1 | One-cycle soft-off request |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. This covers read data, the error flag, the soft-off pulse, and the interrupt level after a register write or a button pulse. The driver records the cycle in which it applies each request and queues the expected result for the next cycle. The monitor compares only when the cycle count reaches that due cycle, and it samples on the falling edge, half a period after the register update. Ignored writes and gated button pulses are confirmed by reading back the affected register in a later access.

// File: rtl/pm_pkg.sv
package pm_pkg;
   localparam logic [15:0] PM_TMR    = 16'h0001;
   localparam logic [15:0] PM_BM     = 16'h0010;
   localparam logic [15:0] PM_GBL    = 16'h0020;
   localparam logic [15:0] PM_PWRBTN = 16'h0100;
   localparam logic [15:0] PM_SLPBTN = 16'h0200;
   localparam logic [15:0] PM_RTC    = 16'h0400;
   localparam logic [15:0] PM_WAK    = 16'h8000;

   // status bits a write-one can clear
   localparam logic [15:0] STS_CLR_MASK = PM_WAK | PM_RTC | PM_SLPBTN | PM_PWRBTN | PM_BM;
   // enable bits that accept writes
   localparam logic [15:0] EN_KEEP_MASK = PM_PWRBTN | PM_GBL;
   // event pairs that can raise the interrupt
   localparam logic [15:0] IRQ_SRC_MASK = PM_TMR | PM_GBL | PM_PWRBTN | PM_SLPBTN | PM_RTC;

   localparam int          CTL_OSCTL_BIT = 0;
   localparam int          CTL_SLPEN_BIT = 13;
   localparam int          CTL_TYP_LO    = 10;
   localparam logic [15:0] CTL_DROP_MASK = 16'h2000 | 16'hC003;

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_STS,
      TGT_EN,
      TGT_CTL,
      TGT_CMD
   } pm_tgt_e;
endpackage

// File: rtl/pm_decode.sv
module pm_decode
   import pm_pkg::*;
#(
   parameter int          ADDR_W   = 16,
   parameter logic [31:0] EVT_BASE = 32'h400,
   parameter logic [31:0] CTL_BASE = 32'h404,
   parameter logic [31:0] CMD_ADDR = 32'hB2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        size,
   output pm_tgt_e           tgt,
   output logic              size_ok
);
   localparam logic [ADDR_W-1:0] A_STS = EVT_BASE[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_EN  = A_STS + ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_CTL = CTL_BASE[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_CMD = CMD_ADDR[ADDR_W-1:0];

   always_comb begin
      tgt = TGT_NONE;
      if (addr == A_STS)      tgt = TGT_STS;
      else if (addr == A_EN)  tgt = TGT_EN;
      else if (addr == A_CTL) tgt = TGT_CTL;
      else if (addr == A_CMD) tgt = TGT_CMD;
   end

   always_comb begin
      unique case (tgt)
         TGT_STS, TGT_EN, TGT_CTL: size_ok = (size == 3'd2);
         TGT_CMD:                  size_ok = (size == 3'd1);
         default:                  size_ok = 1'b1;
      endcase
   end
endmodule

// File: rtl/pm_event_regs.sv
module pm_event_regs
   import pm_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sts_wr,
   input  logic        en_wr,
   input  logic [15:0] wdata,
   input  logic        btn_evt,
   output logic [15:0] sts_q,
   output logic [15:0] en_q,
   output logic        irq_req
);
   logic [15:0] sts_d;

   always_comb begin
      sts_d = sts_q;
      if (sts_wr)
         sts_d = sts_d & ~(wdata & STS_CLR_MASK);
      if (btn_evt && !sts_q[8])
         sts_d = sts_d | PM_PWRBTN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q <= '0;
         en_q  <= '0;
      end else begin
         sts_q <= sts_d;
         if (en_wr)
            en_q <= wdata & EN_KEEP_MASK;
      end
   end

   assign irq_req = |(sts_q & en_q & IRQ_SRC_MASK);
endmodule

// File: rtl/pm_ctrl_regs.sv
module pm_ctrl_regs
   import pm_pkg::*;
#(
   parameter logic [7:0] CMD_ON   = 8'hA0,
   parameter logic [7:0] CMD_OFF  = 8'hA1,
   parameter logic [2:0] OFF_CODE = 3'd5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ctl_wr,
   input  logic        cmd_wr,
   input  logic [15:0] wdata,
   output logic [15:0] ctl_q,
   output logic        soft_off
);
   logic [15:0] ctl_d;
   logic        off_hit;

   always_comb begin
      ctl_d = ctl_q;
      if (ctl_wr) begin
         ctl_d = wdata & ~CTL_DROP_MASK;
         ctl_d[CTL_OSCTL_BIT] = ctl_q[CTL_OSCTL_BIT];
      end else if (cmd_wr) begin
         if (wdata[7:0] == CMD_ON)
            ctl_d[CTL_OSCTL_BIT] = 1'b1;
         else if (wdata[7:0] == CMD_OFF)
            ctl_d[CTL_OSCTL_BIT] = 1'b0;
      end
   end

   assign off_hit = ctl_wr && wdata[CTL_SLPEN_BIT] &&
                    (wdata[CTL_TYP_LO +: 3] == OFF_CODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q    <= '0;
         soft_off <= 1'b0;
      end else begin
         ctl_q    <= ctl_d;
         soft_off <= off_hit;
      end
   end
endmodule

// File: rtl/pm_fixed_regs.sv
module pm_fixed_regs
   import pm_pkg::*;
#(
   parameter int          ADDR_W         = 16,
   parameter logic [31:0] EVT_BASE       = 32'h400,
   parameter logic [31:0] CTL_BASE       = 32'h404,
   parameter logic [31:0] CMD_ADDR       = 32'hB2,
   parameter logic [7:0]  CMD_ON         = 8'hA0,
   parameter logic [7:0]  CMD_OFF        = 8'hA1,
   parameter logic [2:0]  OFF_CODE       = 3'd5,
   parameter bit          SCI_ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_req,
   input  logic              io_we,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [2:0]        io_size,
   input  logic [15:0]       io_wdata,
   output logic [15:0]       io_rdata,
   output logic              io_err,
   input  logic              pwr_btn,
   output logic              sci_irq,
   output logic              soft_off
);
   localparam logic [31:0] ADDR_SPAN = 32'd1 << ADDR_W;

   generate
      if (ADDR_W < 8 || ADDR_W > 31) begin : g_bad_width
         $error("pm_fixed_regs: ADDR_W out of range");
      end
      if ((EVT_BASE + 32'd4) > ADDR_SPAN || (CTL_BASE + 32'd2) > ADDR_SPAN ||
          CMD_ADDR >= ADDR_SPAN) begin : g_bad_map
         $error("pm_fixed_regs: register address outside ADDR_W");
      end
      if (EVT_BASE[0] || CTL_BASE[0]) begin : g_bad_align
         $error("pm_fixed_regs: 16-bit registers must be even aligned");
      end
   endgenerate

   pm_tgt_e     tgt;
   logic        size_ok;
   logic        acc_ok;
   logic [15:0] sts_q;
   logic [15:0] en_q;
   logic [15:0] ctl_q;
   logic        irq_req;
   logic        btn_evt;

   pm_decode #(
      .ADDR_W   (ADDR_W),
      .EVT_BASE (EVT_BASE),
      .CTL_BASE (CTL_BASE),
      .CMD_ADDR (CMD_ADDR)
   ) u_dec (
      .addr    (io_addr),
      .size    (io_size),
      .tgt     (tgt),
      .size_ok (size_ok)
   );

   assign acc_ok  = io_req && (tgt != TGT_NONE) && size_ok;
   assign btn_evt = pwr_btn && ctl_q[CTL_OSCTL_BIT];

   pm_event_regs u_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .sts_wr  (acc_ok && io_we && tgt == TGT_STS),
      .en_wr   (acc_ok && io_we && tgt == TGT_EN),
      .wdata   (io_wdata),
      .btn_evt (btn_evt),
      .sts_q   (sts_q),
      .en_q    (en_q),
      .irq_req (irq_req)
   );

   pm_ctrl_regs #(
      .CMD_ON   (CMD_ON),
      .CMD_OFF  (CMD_OFF),
      .OFF_CODE (OFF_CODE)
   ) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (acc_ok && io_we && tgt == TGT_CTL),
      .cmd_wr   (acc_ok && io_we && tgt == TGT_CMD),
      .wdata    (io_wdata),
      .ctl_q    (ctl_q),
      .soft_off (soft_off)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         io_rdata <= '0;
         io_err   <= 1'b0;
      end else begin
         io_err   <= io_req && (tgt != TGT_NONE) && !size_ok;
         io_rdata <= '0;
         if (acc_ok && !io_we) begin
            unique case (tgt)
               TGT_STS: io_rdata <= sts_q;
               TGT_EN:  io_rdata <= en_q;
               TGT_CTL: io_rdata <= ctl_q;
               default: io_rdata <= '0;
            endcase
         end
      end
   end

   generate
      if (SCI_ACTIVE_LOW) begin : g_irq_lo
         assign sci_irq = ~irq_req;
      end else begin : g_irq_hi
         assign sci_irq = irq_req;
      end
   endgenerate
endmodule

// File: rtl/pm_fixed_regs_chk.sv
module pm_fixed_regs_chk #(
   parameter int          ADDR_W         = 16,
   parameter logic [31:0] EVT_BASE       = 32'h400,
   parameter logic [31:0] CTL_BASE       = 32'h404,
   parameter bit          SCI_ACTIVE_LOW = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              io_req,
   input logic              io_we,
   input logic [ADDR_W-1:0] io_addr,
   input logic [2:0]        io_size,
   input logic [15:0]       io_wdata,
   input logic [15:0]       io_rdata,
   input logic              io_err,
   input logic              pwr_btn,
   input logic              sci_irq,
   input logic              soft_off,
   input logic [15:0]       sts_q,
   input logic [15:0]       ctl_q
);
   localparam logic [ADDR_W-1:0] C_STS = EVT_BASE[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] C_EN  = C_STS + ADDR_W'(2);
   localparam logic [ADDR_W-1:0] C_CTL = CTL_BASE[ADDR_W-1:0];
   localparam logic              IDLE  = SCI_ACTIVE_LOW;

   logic word_reg;
   assign word_reg = (io_addr == C_STS) || (io_addr == C_EN) || (io_addr == C_CTL);

   AST_BAD_SIZE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      io_req && word_reg && io_size != 3'd2 |=> io_err && io_rdata == 16'h0); // R1

   AST_EN_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      io_req && !io_we && io_addr == C_EN && io_size == 3'd2 |=> (io_rdata & ~16'h0120) == 16'h0); // R3

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      io_req && io_we && io_addr == C_EN && io_size == 3'd2 && io_wdata == 16'h0 |=> sci_irq == IDLE); // R4

   AST_BTN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_btn && !ctl_q[0] && !io_req |=> $stable(sts_q)); // R5

   AST_OSCTL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      io_req && io_we && io_addr == C_CTL && io_size == 3'd2 |=> $stable(ctl_q[0])); // R7

   AST_SOFTOFF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      soft_off |-> $past(io_req && io_we && io_addr == C_CTL && io_wdata[13])); // R8
endmodule

bind pm_fixed_regs pm_fixed_regs_chk #(
   .ADDR_W         (ADDR_W),
   .EVT_BASE       (EVT_BASE),
   .CTL_BASE       (CTL_BASE),
   .SCI_ACTIVE_LOW (SCI_ACTIVE_LOW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .io_req   (io_req),
   .io_we    (io_we),
   .io_addr  (io_addr),
   .io_size  (io_size),
   .io_wdata (io_wdata),
   .io_rdata (io_rdata),
   .io_err   (io_err),
   .pwr_btn  (pwr_btn),
   .sci_irq  (sci_irq),
   .soft_off (soft_off),
   .sts_q    (sts_q),
   .ctl_q    (ctl_q)
);

// File: tb/sim_pm_fixed_regs.sv
`timescale 1ns/1ps
module sim_pm_fixed_regs;
   localparam logic [15:0] A_STS = 16'h0400;
   localparam logic [15:0] A_EN  = 16'h0402;
   localparam logic [15:0] A_CTL = 16'h0404;
   localparam logic [15:0] A_CMD = 16'h00B2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_req = 1'b0;
   logic        io_we = 1'b0;
   logic [15:0] io_addr = '0;
   logic [2:0]  io_size = '0;
   logic [15:0] io_wdata = '0;
   logic [15:0] io_rdata;
   logic        io_err;
   logic        pwr_btn = 1'b0;
   logic        sci_irq;
   logic        soft_off;

   always #4 clk = ~clk;

   pm_fixed_regs u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .io_req   (io_req),
      .io_we    (io_we),
      .io_addr  (io_addr),
      .io_size  (io_size),
      .io_wdata (io_wdata),
      .io_rdata (io_rdata),
      .io_err   (io_err),
      .pwr_btn  (pwr_btn),
      .sci_irq  (sci_irq),
      .soft_off (soft_off)
   );

   typedef struct {
      int          due;
      bit          chk_rd;
      logic [15:0] rd;
      logic        err;
      logic        irq;
      logic        off;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   int          cyc = 0;
   int          checks = 0;
   int          failures = 0;
   bit          done = 1'b0;
   logic [15:0] m_sts = '0, m_en = '0, m_ctl = '0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic model_irq();
      return !(|(m_sts & m_en & 16'h0721));
   endfunction

   task automatic push(bit chk_rd, logic [15:0] rd, logic err, logic off, string tag);
      exp_t e;
      e.due = cyc + 1; e.chk_rd = chk_rd; e.rd = rd; e.err = err;
      e.irq = model_irq(); e.off = off; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic access(bit we, logic [15:0] a, logic [2:0] sz, logic [15:0] d, string tag);
      bit          mapped, ok, off;
      logic [15:0] rd;
      @(negedge clk);
      io_req = 1'b1; io_we = we; io_addr = a; io_size = sz; io_wdata = d;
      mapped = (a == A_STS) || (a == A_EN) || (a == A_CTL) || (a == A_CMD);
      ok = (a == A_CMD) ? (sz == 3'd1) : (!mapped || sz == 3'd2);
      rd = '0; off = 1'b0;
      if (mapped && ok) begin
         if (!we) begin
            if (a == A_STS) rd = m_sts;
            else if (a == A_EN) rd = m_en;
            else if (a == A_CTL) rd = m_ctl;
         end else if (a == A_STS) begin
            m_sts = m_sts & ~(d & 16'h8710);
         end else if (a == A_EN) begin
            m_en = d & 16'h0120;
         end else if (a == A_CTL) begin
            off = d[13] && (d[12:10] == 3'd5);
            m_ctl = (d & 16'h1FFC) | (m_ctl & 16'h0001);
         end else begin
            if (d[7:0] == 8'hA0) m_ctl[0] = 1'b1;
            else if (d[7:0] == 8'hA1) m_ctl[0] = 1'b0;
         end
      end
      push(!we, rd, mapped && !ok, off, tag);
      @(negedge clk);
      io_req = 1'b0; io_we = 1'b0;
   endtask

   task automatic press(string tag);
      @(negedge clk);
      pwr_btn = 1'b1;
      if (m_ctl[0]) m_sts = m_sts | 16'h0100;
      push(1'b0, '0, 1'b0, 1'b0, tag);
      @(negedge clk);
      pwr_btn = 1'b0;
   endtask

   always @(negedge clk) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if ((e.chk_rd && io_rdata !== e.rd) || io_err !== e.err ||
             sci_irq !== e.irq || soft_off !== e.off) begin
            failures++;
            $display("FAIL %s: rdata=%h err=%b irq=%b off=%b expected rdata=%h err=%b irq=%b off=%b",
                     e.tag, io_rdata, io_err, sci_irq, soft_off,
                     e.chk_rd ? e.rd : io_rdata, e.err, e.irq, e.off);
         end
      end
   end

   initial begin
      #(8 * 5000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state
      access(0, A_STS, 3'd2, 0, "R9 status after reset");
      access(0, A_EN,  3'd2, 0, "R9 enable after reset");
      access(0, A_CTL, 3'd2, 0, "R9 control after reset");
      // R10 unmapped
      access(0, 16'h0300, 3'd2, 0, "R10 unmapped read");
      // R3 enable mask
      access(1, A_EN, 3'd2, 16'hFFFF, "R3 enable write");
      access(0, A_EN, 3'd2, 0, "R3 enable readback");
      // R5 button ignored while OS control off
      press("R5 gated press");
      access(0, A_STS, 3'd2, 0, "R5 status after gated press");
      // R6 command port
      access(0, A_CMD, 3'd1, 0, "R6 command read");
      access(1, A_CMD, 3'd1, 16'h0055, "R6 other command");
      access(0, A_CTL, 3'd2, 0, "R6 control after other command");
      // R1 wrong size on command port
      access(1, A_CMD, 3'd2, 16'h00A0, "R1 command wrong size");
      access(0, A_CTL, 3'd2, 0, "R1 control unchanged");
      access(1, A_CMD, 3'd1, 16'h00A0, "R6 enable command");
      access(0, A_CTL, 3'd2, 0, "R6 control bit0 set");
      // R5 / R4 button raises interrupt
      press("R5 R4 armed press");
      press("R5 second press");
      access(0, A_STS, 3'd2, 0, "R5 status after press");
      access(1, A_EN, 3'd2, 16'h0000, "R4 disable clears irq");
      access(1, A_EN, 3'd2, 16'h0100, "R4 enable raises irq");
      // R1 wrong-size status write
      access(1, A_STS, 3'd1, 16'hFFFF, "R1 status byte write");
      access(0, A_STS, 3'd4, 0, "R1 status dword read");
      // R2 write-one-to-clear
      access(1, A_STS, 3'd2, 16'h0000, "R2 zero write");
      access(0, A_STS, 3'd2, 0, "R2 status kept");
      access(1, A_STS, 3'd2, 16'h0100, "R2 clear pwrbtn");
      access(0, A_STS, 3'd2, 0, "R2 status cleared");
      // R7 control masking
      access(1, A_CTL, 3'd2, 16'hFFFE, "R7 control write");
      access(0, A_CTL, 3'd2, 0, "R7 control readback");
      // R8 soft-off
      access(1, A_CTL, 3'd2, 16'h3400, "R8 soft-off write");
      access(0, A_CTL, 3'd2, 0, "R8 pulse ended");
      access(1, A_CTL, 3'd2, 16'h1400, "R8 no sleep enable");
      access(1, A_CTL, 3'd2, 16'h2C00, "R8 other sleep type");
      // R6 disable, R5 gated again
      access(1, A_CMD, 3'd1, 16'h00A1, "R6 disable command");
      access(0, A_CTL, 3'd2, 0, "R6 control bit0 cleared");
      press("R5 press after disable");
      access(0, A_STS, 3'd2, 0, "R5 status stays clear");
      repeat (3) @(negedge clk);
      if (sb.size() != 0) begin
         failures++;
         $display("FAIL R10: %0d results never checked, expected 0", sb.size());
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule